// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block takes control of an 8-bit microcontroller core for the few cycles in which an interrupt is entered. While idle it watches a reset request, a 64-bit vector of pending hardware sources, the global interrupt enable and a flag that says a conditional skip is still outstanding. When it accepts an entry, it captures the program counter and stack pointer. It then writes the return address onto the byte-wide data stack through a plain write port, one byte per cycle. Finally it reports the vector address for the core to jump to, together with the bookkeeping the core must apply: clear the global enable, drop the serviced pending bit, and acknowledge a reset request.

The sequencer has five states. IDLE waits for an acceptable request; on acceptance it goes to PUSH0. PUSH0 stores the low byte, then goes to PUSH1 when at least two bytes are configured, otherwise to JUMP. PUSH1 stores the middle byte, then goes to PUSH2 when three bytes are configured, otherwise to JUMP. PUSH2 stores the top byte and goes to JUMP. JUMP presents the result for one cycle and returns to IDLE.

Two configuration straps are sampled at acceptance. One selects the return-address width (one, two or three bytes). The other selects whether vector slots are two words apart (long jump present) or one.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_pend` is 1 no request is accepted: `busy` and `mem_we` stay 0. Acceptance happens on the first clock edge after the skip flag drops.
- R2: With `gie` at 0 neither a reset request nor a hardware request is accepted.
- R3: A reset request wins over any pending hardware bits. It uses vector number 0, pulses `rst_ack` in the JUMP cycle and leaves `pend_clr` at 0.
- R4: For a hardware entry the source is the lowest-numbered set bit of `irq_pend`, and the vector number is that bit index plus one.
- R5: `new_pc` equals the vector number times 2 when `cfg_long_vec` is 1, and times 1 when it is 0.
- R6: The return PC is written low byte first. The first write goes to the captured stack pointer, and each later write goes to an address one lower. There is one write per cycle, and the first write comes in the cycle after the accepting edge.
- R7: `cfg_pc_bytes` selects how many bytes are written: 3 writes bits 7:0, 15:8 and 23:16; 2 writes the first two; any other value writes only bits 7:0. In the JUMP cycle `sp_out` equals the captured stack pointer minus the byte count.
- R8: `done` is a one-cycle pulse in the cycle after the last write. It comes with `gie_clr` and a valid `new_pc`, and `busy` is 0 on the following cycle.
- R9: `pend_clr` is one-hot on the bit latched at acceptance, even if a lower-numbered bit becomes pending during the sequence.
- R10: `hw_all_clr` is 1 in the JUMP cycle of a hardware entry exactly when no bit of `irq_pend` other than the serviced one is set. It is 0 for reset entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rst_req | input | 1 | Pending reset request |
| irq_pend | input | NSRC | Pending hardware sources, bit i is source i |
| gie | input | 1 | Global interrupt enable |
| skip_pend | input | 1 | A conditional skip is outstanding |
| pc_in | input | PC_W | Current word program counter |
| sp_in | input | SP_W | Current stack pointer |
| cfg_pc_bytes | input | 2 | Return address size strap (3, 2, else 1 byte) |
| cfg_long_vec | input | 1 | Vector slots are two words apart |
| busy | output | 1 | Sequence in progress |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | SP_W | Stack write address |
| mem_wdata | output | 8 | Stack write data |
| done | output | 1 | One-cycle completion strobe |
| new_pc | output | PC_W | Vector word address, valid with done |
| sp_out | output | SP_W | Updated stack pointer, valid with done |
| gie_clr | output | 1 | Clear the global enable, with done |
| rst_ack | output | 1 | Reset request serviced, with done |
| pend_clr | output | NSRC | One-hot mask of the serviced bit, with done |
| hw_all_clr | output | 1 | No hardware bits remain after this clear |

## Verification
Two functions can meet in the JUMP cycle: the serviced bit is cleared, and the remaining-pending check is made against whatever has arrived since acceptance. The bench provokes this by raising a lower-numbered bit during the first push. It then expects `pend_clr` to keep the originally latched bit and expects `hw_all_clr` to drop. A second meeting occurs when a reset request and hardware bits are present on the same accepting edge. The bench judges that by the vector, `rst_ack` and an empty clear mask. Full sweeps over every source index, byte count and vector spacing compare each write and result with values computed arithmetically.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_PUSH0 = 3'd1,
        S_PUSH1 = 3'd2,
        S_PUSH2 = 3'd3,
        S_JUMP  = 3'd4
    } seq_state_t;

    localparam int MAX_PC_BYTES = 3;

endpackage

// File: rtl/irq_lowest_pick.sv
module irq_lowest_pick #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     pend,
    output logic             valid,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        valid = |pend;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/irq_vec_addr.sv
module irq_vec_addr #(
    parameter int VN_W = 7,
    parameter int PC_W = 22
) (
    input  logic [VN_W-1:0] vnum,
    input  logic            long_slot,
    output logic [PC_W-1:0] vpc
);

    always_comb begin
        if (long_slot) vpc = PC_W'({vnum, 1'b0});
        else           vpc = PC_W'(vnum);
    end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NSRC = 64,
    parameter int PC_W = 22,
    parameter int SP_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            rst_req,
    input  logic [NSRC-1:0] irq_pend,
    input  logic            gie,
    input  logic            skip_pend,
    input  logic [PC_W-1:0] pc_in,
    input  logic [SP_W-1:0] sp_in,
    input  logic [1:0]      cfg_pc_bytes,
    input  logic            cfg_long_vec,
    output logic            busy,
    output logic            mem_we,
    output logic [SP_W-1:0] mem_addr,
    output logic [7:0]      mem_wdata,
    output logic            done,
    output logic [PC_W-1:0] new_pc,
    output logic [SP_W-1:0] sp_out,
    output logic            gie_clr,
    output logic            rst_ack,
    output logic [NSRC-1:0] pend_clr,
    output logic            hw_all_clr
);

    localparam int IDX_W = $clog2(NSRC);
    localparam int VN_W  = $clog2(NSRC + 1);
    localparam int PCX_W = 8 * MAX_PC_BYTES;

    seq_state_t state_q, state_d;

    logic             pick_valid;
    logic [IDX_W-1:0] pick_idx;
    logic             take;

    logic             is_rst_q;
    logic [IDX_W-1:0] idx_q;
    logic [PC_W-1:0]  pc_q;
    logic [SP_W-1:0]  sp_q;
    logic [1:0]       nb_q;
    logic             long_q;

    logic [VN_W-1:0]  vnum;
    logic [PC_W-1:0]  vec_pc;
    logic [PCX_W-1:0] pc_ext;
    logic [NSRC-1:0]  clr_mask;

    irq_lowest_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
        .pend  (irq_pend),
        .valid (pick_valid),
        .idx   (pick_idx)
    );

    assign vnum = is_rst_q ? '0 : VN_W'(idx_q) + VN_W'(1);

    irq_vec_addr #(.VN_W(VN_W), .PC_W(PC_W)) u_vec (
        .vnum      (vnum),
        .long_slot (long_q),
        .vpc       (vec_pc)
    );

    // acceptance: skip outstanding or global enable low blocks everything
    assign take     = gie && !skip_pend && (rst_req || pick_valid);
    assign pc_ext   = PCX_W'(pc_q);
    assign clr_mask = NSRC'(1) << idx_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (take) state_d = S_PUSH0;
            S_PUSH0: state_d = (nb_q >= 2'd2) ? S_PUSH1 : S_JUMP;
            S_PUSH1: state_d = (nb_q == 2'd3) ? S_PUSH2 : S_JUMP;
            S_PUSH2: state_d = S_JUMP;
            S_JUMP:  state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            is_rst_q <= 1'b0;
            idx_q    <= '0;
            pc_q     <= '0;
            sp_q     <= '0;
            nb_q     <= 2'd1;
            long_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == S_IDLE && take) begin
                is_rst_q <= rst_req;
                idx_q    <= pick_idx;
                pc_q     <= pc_in;
                sp_q     <= sp_in;
                long_q   <= cfg_long_vec;
                nb_q     <= (cfg_pc_bytes == 2'd3) ? 2'd3 :
                            (cfg_pc_bytes == 2'd2) ? 2'd2 : 2'd1;
            end else if (state_q == S_PUSH0 || state_q == S_PUSH1 ||
                         state_q == S_PUSH2) begin
                sp_q <= sp_q - SP_W'(1);
            end
        end
    end

    always_comb begin
        busy       = (state_q != S_IDLE);
        mem_we     = 1'b0;
        mem_addr   = sp_q;
        mem_wdata  = 8'h00;
        done       = 1'b0;
        new_pc     = vec_pc;
        sp_out     = sp_q;
        gie_clr    = 1'b0;
        rst_ack    = 1'b0;
        pend_clr   = '0;
        hw_all_clr = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_PUSH0: begin
                mem_we    = 1'b1;
                mem_wdata = pc_ext[7:0];
            end
            S_PUSH1: begin
                mem_we    = 1'b1;
                mem_wdata = pc_ext[15:8];
            end
            S_PUSH2: begin
                mem_we    = 1'b1;
                mem_wdata = pc_ext[23:16];
            end
            S_JUMP: begin
                done    = 1'b1;
                gie_clr = 1'b1;
                rst_ack = is_rst_q;
                if (!is_rst_q) begin
                    pend_clr   = clr_mask;
                    hw_all_clr = ((irq_pend & ~clr_mask) == '0);
                end
            end
            default: ;
        endcase
    end

    p_skip_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && skip_pend) |=> !busy);

    p_gie_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gie) |=> !busy);

    p_reset_vec_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rst_ack) |-> (new_pc == '0 && pend_clr == '0));

    p_sp_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SP_W'(1)));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && !busy));

    p_done_gie_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> gie_clr);

    p_clr_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pend_clr));

    p_clr_only_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_clr != '0) |-> done);

endmodule

// File: tb/sim_irq_entry_seq.sv
module sim_irq_entry_seq;

    localparam int NSRC = 64;
    localparam int PC_W = 22;
    localparam int SP_W = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            rst_req = 1'b0;
    logic [NSRC-1:0] irq_pend = '0;
    logic            gie = 1'b0;
    logic            skip_pend = 1'b0;
    logic [PC_W-1:0] pc_in = '0;
    logic [SP_W-1:0] sp_in = '0;
    logic [1:0]      cfg_pc_bytes = 2'd1;
    logic            cfg_long_vec = 1'b0;
    logic            busy, mem_we, done, gie_clr, rst_ack, hw_all_clr;
    logic [SP_W-1:0] mem_addr, sp_out;
    logic [7:0]      mem_wdata;
    logic [PC_W-1:0] new_pc;
    logic [NSRC-1:0] pend_clr;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    irq_entry_seq #(.NSRC(NSRC), .PC_W(PC_W), .SP_W(SP_W)) u0 (
        .clk, .rst_n, .rst_req, .irq_pend, .gie, .skip_pend, .pc_in, .sp_in,
        .cfg_pc_bytes, .cfg_long_vec, .busy, .mem_we, .mem_addr, .mem_wdata,
        .done, .new_pc, .sp_out, .gie_clr, .rst_ack, .pend_clr, .hw_all_clr
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic entry(input bit rq, input logic [NSRC-1:0] pend,
                         input logic [PC_W-1:0] pc, input logic [SP_W-1:0] sp,
                         input logic [1:0] cb, input bit lng, input int late);
        int n;
        int lo;
        logic [NSRC-1:0] msk;
        logic [23:0] pcx;
        logic [PC_W-1:0] exp_pc;
        @(negedge clk);
        rst_req = rq; irq_pend = pend; pc_in = pc; sp_in = sp;
        cfg_pc_bytes = cb; cfg_long_vec = lng; gie = 1'b1; skip_pend = 1'b0;
        n   = (cb == 2'd3) ? 3 : (cb == 2'd2) ? 2 : 1;
        lo  = 0;
        for (int i = NSRC - 1; i >= 0; i--) if (pend[i]) lo = i;
        msk = rq ? '0 : (NSRC'(1) << lo);
        exp_pc = rq ? '0 : PC_W'((lo + 1) * (lng ? 2 : 1));
        pcx = 24'(pc);
        @(negedge clk);
        for (int k = 0; k < n; k++) begin
            chk(mem_we == 1'b1, "R6 write strobe", 64'(mem_we), 64'd1);
            chk(mem_addr == sp - SP_W'(k), "R6 write address", 64'(mem_addr),
                64'(sp - SP_W'(k)));
            chk(mem_wdata == pcx[8*k +: 8], "R7 byte order", 64'(mem_wdata),
                64'(pcx[8*k +: 8]));
            if (k == 0 && late >= 0) irq_pend = irq_pend | (NSRC'(1) << late);
            @(negedge clk);
        end
        chk(done == 1'b1 && mem_we == 1'b0, "R8 done after last write",
            64'({done, mem_we}), 64'b10);
        chk(gie_clr == 1'b1, "R8 gie clear", 64'(gie_clr), 64'd1);
        chk(new_pc == exp_pc, rq ? "R3 reset vector" : "R4 R5 vector address",
            64'(new_pc), 64'(exp_pc));
        chk(sp_out == sp - SP_W'(n), "R7 stack pointer", 64'(sp_out),
            64'(sp - SP_W'(n)));
        chk(rst_ack == rq, "R3 reset ack", 64'(rst_ack), 64'(rq));
        chk(pend_clr == msk, "R9 clear mask", pend_clr, msk);
        chk(hw_all_clr == (!rq && ((irq_pend & ~msk) == '0)), "R10 all clear",
            64'(hw_all_clr), 64'(!rq && ((irq_pend & ~msk) == '0)));
        gie = 1'b0; rst_req = 1'b0; irq_pend = irq_pend & ~msk;
        @(negedge clk);
        chk(busy == 1'b0 && done == 1'b0, "R8 back to idle", 64'({busy, done}), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 0 && mem_we == 0 && done == 0, "R8 reset state",
            64'({busy, mem_we, done}), 64'd0);

        // R1: skip pending blocks acceptance
        irq_pend = NSRC'(1) << 5; gie = 1'b1; skip_pend = 1'b1;
        sp_in = 16'h0400; pc_in = 22'h001234; cfg_pc_bytes = 2'd2;
        repeat (4) @(negedge clk);
        chk(busy == 0 && mem_we == 0, "R1 skip blocks", 64'({busy, mem_we}), 64'd0);
        skip_pend = 1'b0;
        @(negedge clk);
        chk(busy == 1 && mem_we == 1 && mem_addr == 16'h0400, "R1 accept after skip",
            64'({busy, mem_we}), 64'b11);
        repeat (3) @(negedge clk);
        gie = 1'b0; irq_pend = '0;
        @(negedge clk);

        // R2: global enable low blocks reset and hardware requests
        rst_req = 1'b1; irq_pend = NSRC'(1);
        repeat (4) @(negedge clk);
        chk(busy == 0 && mem_we == 0, "R2 gie blocks", 64'({busy, mem_we}), 64'd0);
        rst_req = 1'b0; irq_pend = '0;

        // R3: reset beats hardware bits, every byte count
        for (int c = 0; c < 4; c++)
            entry(1'b1, NSRC'(1) << 7, 22'h3ABCDE, 16'h08FF, 2'(c), c[0], -1);

        // R4 R5 R6 R7: sweep every source, byte count and spacing
        for (int c = 1; c < 4; c++)
            for (int l = 0; l < 2; l++)
                for (int i = 0; i < NSRC; i++)
                    entry(1'b0,
                          (NSRC'(1) << i) | ((i % 2 == 1) ? (NSRC'(1) << (NSRC - 1)) : '0),
                          PC_W'(i * 40503 + c * 977 + l * 3),
                          SP_W'(16'h0FFF - i * 5 - c), 2'(c), l[0], -1);

        // R4: multi-bit patterns
        for (int t = 0; t < 16; t++)
            entry(1'b0, {32'hA5000000 >> t, 32'h80000000 >> (t * 2)},
                  PC_W'(22'h155555 + t), 16'h0100, 2'd3, 1'b1, -1);

        // R9 R10: lower bit arrives during the sequence
        entry(1'b0, NSRC'(1) << 20, 22'h2F0F0F, 16'h0300, 2'd3, 1'b0, 3);
        chk(irq_pend == (NSRC'(1) << 3), "R9 late bit kept", irq_pend, NSRC'(1) << 3);
        entry(1'b0, irq_pend, 22'h000010, 16'h0300, 2'd1, 1'b1, -1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule